// File: doc/BRIEF.md
# Seven-Port Buffered Message Crosspoint

This block is a switch that moves fixed-width messages between seven ports. Each port pushes words into its own small register FIFO through a valid/ready handshake. In every cycle, one central combinational stage does three things for all ports at once. It looks up the destination of the word at the head of each FIFO in a programmable routing table. It lets each output choose one of the other six ports in round-robin order. It places the chosen words in the output registers. An output register drives a word with a valid flag for one cycle. The output side has no back-pressure.

The back-pressure rules at an input are as follows. A word is taken at a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is low only while that port's FIFO holds its full four words. A sender that sees `in_ready` low keeps its word and valid steady until the word is taken. A head word that loses arbitration stays at the FIFO head, which is what stalls the port. The routing table is written one entry per cycle through a plain write strobe.

Top module: `msg_xpoint`

## Requirements
- R1: After reset, `in_ready` is all ones, `out_valid` and `loop_err` are low, and routing entry n holds port n mod 7.
- R2: A word is taken at an edge where `in_valid` and `in_ready` are both high. `in_ready` of a port is low exactly while its FIFO holds 4 words.
- R3: Every taken word that is not discarded leaves exactly once. Words from one input to one output leave in the order they were taken.
- R4: The destination identifier is bits [44:40] of a word. The word leaves on the output port that the routing table holds for that identifier, never on its own input port.
- R5: An uncontended word taken at edge k appears on its output at edge k+1, and a port sustains one word per clock.
- R6: When several inputs contend for one output, the output grants the first requester found by scanning upward, with wrap, from the port after the one it granted last. The scan starts at port 0 after reset.
- R7: A head word that loses arbitration stays at its FIFO head and is sent later, unchanged.
- R8: A head word whose routing entry names its own arrival port is dropped within one cycle and sets `loop_err`. `loop_err` stays high until reset.
- R9: With `tbl_we` high at an edge, entry `tbl_addr` takes `tbl_port`. A write whose port value is 7 or more is ignored.
- R10: `out_valid` of an output is low in any cycle after an edge at which no word was granted to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 7 | Per-port word offered |
| in_data | input | 315 | Seven 45-bit words, port n at bits [45n+44:45n] |
| in_ready | output | 7 | Per-port FIFO has room |
| out_valid | output | 7 | Per-port registered word valid |
| out_data | output | 315 | Seven registered 45-bit words, same packing as `in_data` |
| tbl_we | input | 1 | Routing table write strobe |
| tbl_addr | input | 5 | Routing entry index (destination identifier) |
| tbl_port | input | 3 | Output port number to store |
| loop_err | output | 1 | Sticky flag for a discarded self-routed word |

## Verification
A round-robin pointer that is off by one shows at the ports within one contended cycle, as a wrong source at the contested output. A FIFO count that drifts shows as a wrong `in_ready` compared with a queue model, or as a lost or repeated word on the next delivery. A wrong routing entry sends a word to the wrong output one cycle after it reaches the head. A stuck entry leaves the word unsent, so the model sees the word missing from then on. The bench predicts every output and every ready flag from behavioural queues and compares them on every clock, so each of these faults is caught in the cycle where it first appears.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int XPT_NPORT = 7;
  localparam int XPT_MSG_W = 45;
  localparam int XPT_ID_W  = 5;
  localparam int XPT_DEPTH = 4;

  // round-robin successor of a port index
  function automatic int xpt_next(input int idx, input int n);
    return (idx == n - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/xpt_fifo.sv
module xpt_fifo #(
  parameter int W     = 45,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full,
  output logic         head_valid,
  output logic [W-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= adv(wr_q);
      if (pop)  rd_q <= adv(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign full       = (cnt_q == CW'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head       = mem[rd_q];

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
endmodule

// File: rtl/xpt_route_tbl.sv
module xpt_route_tbl #(
  parameter int NPORT = 7,
  parameter int ID_W  = 5,
  parameter int PW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ID_W-1:0]             waddr,
  input  logic [PW-1:0]               wport,
  output logic [(1<<ID_W)*PW-1:0]     tbl_flat
);
  localparam int TBL_N = 1 << ID_W;

  logic [PW-1:0] ent_q [TBL_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_N; i++) ent_q[i] <= PW'(i % NPORT);
    end else if (we && (int'(wport) < NPORT)) begin
      ent_q[waddr] <= wport;
    end
  end

  always_comb begin
    for (int i = 0; i < TBL_N; i++) tbl_flat[i*PW +: PW] = ent_q[i];
  end

  generate
    for (genvar g = 0; g < TBL_N; g++) begin : g_rng
      // R9
      entry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ent_q[g]) < NPORT);
    end
  endgenerate
endmodule

// File: rtl/xpt_rr_arb.sv
module xpt_rr_arb #(
  parameter int N  = 7,
  parameter int PW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [PW-1:0] win,
  output logic          any
);
  always_comb begin
    int idx;
    gnt = '0;
    win = '0;
    any = 1'b0;
    idx = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        win      = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/xpt_central.sv
module xpt_central #(
  parameter int N     = 7,
  parameter int MSG_W = 45,
  parameter int ID_W  = 5,
  parameter int PW    = 3
) (
  input  logic [N-1:0]              head_valid,
  input  logic [N*MSG_W-1:0]        head_data,
  input  logic [(1<<ID_W)*PW-1:0]   tbl_flat,
  input  logic [N*PW-1:0]           ptr_flat,
  output logic [N-1:0]              pop,
  output logic [N-1:0]              loop_hit,
  output logic [N-1:0]              sel_valid,
  output logic [N*MSG_W-1:0]        sel_data,
  output logic [N*PW-1:0]           win_flat,
  output logic [N*N-1:0]            gnt_flat
);
  localparam int ID_LSB = MSG_W - ID_W;

  logic [PW-1:0] dst [N];
  logic [N-1:0]  req [N];
  logic [N-1:0]  gnt [N];

  // destination decode for every head word
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [ID_W-1:0] id;
      id          = head_data[i*MSG_W + ID_LSB +: ID_W];
      dst[i]      = tbl_flat[int'(id)*PW +: PW];
      loop_hit[i] = head_valid[i] && (dst[i] == PW'(i));
    end
  end

  // request matrix: output o, input i; never its own port
  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        req[o][i] = head_valid[i] && (dst[i] == PW'(o)) && (i != o);
  end

  generate
    for (genvar o = 0; o < N; o++) begin : g_out
      xpt_rr_arb #(.N(N), .PW(PW)) u_arb (
        .req (req[o]),
        .ptr (ptr_flat[o*PW +: PW]),
        .gnt (gnt[o]),
        .win (win_flat[o*PW +: PW]),
        .any (sel_valid[o])
      );
    end
  endgenerate

  // one-hot select of the granted head word
  always_comb begin
    for (int o = 0; o < N; o++) begin
      logic [MSG_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < N; i++)
        acc = acc | ({MSG_W{gnt[o][i]}} & head_data[i*MSG_W +: MSG_W]);
      sel_data[o*MSG_W +: MSG_W] = acc;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic p;
      p = loop_hit[i];
      for (int o = 0; o < N; o++) p = p | gnt[o][i];
      pop[i] = p;
    end
    for (int o = 0; o < N; o++) gnt_flat[o*N +: N] = gnt[o];
  end
endmodule

// File: rtl/msg_xpoint.sv
module msg_xpoint #(
  parameter int NPORT = xpt_pkg::XPT_NPORT,
  parameter int MSG_W = xpt_pkg::XPT_MSG_W,
  parameter int ID_W  = xpt_pkg::XPT_ID_W,
  parameter int DEPTH = xpt_pkg::XPT_DEPTH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           in_valid,
  input  logic [NPORT*MSG_W-1:0]     in_data,
  output logic [NPORT-1:0]           in_ready,
  output logic [NPORT-1:0]           out_valid,
  output logic [NPORT*MSG_W-1:0]     out_data,
  input  logic                       tbl_we,
  input  logic [ID_W-1:0]            tbl_addr,
  input  logic [$clog2(NPORT)-1:0]   tbl_port,
  output logic                       loop_err
);
  localparam int PW = $clog2(NPORT);

  logic [NPORT-1:0]           full, head_valid, push, pop, loop_hit, sel_valid;
  logic [NPORT*MSG_W-1:0]     head_data, sel_data;
  logic [(1<<ID_W)*PW-1:0]    tbl_flat;
  logic [NPORT*PW-1:0]        ptr_flat, win_flat;
  logic [NPORT*NPORT-1:0]     gnt_flat;
  logic [PW-1:0]              ptr_q [NPORT];
  logic [NPORT-1:0]           out_valid_q;
  logic [NPORT*MSG_W-1:0]     out_data_q;
  logic                       loop_err_q;

  assign in_ready = ~full;
  assign push     = in_valid & ~full;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_in
      xpt_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push[p]),
        .din        (in_data[p*MSG_W +: MSG_W]),
        .pop        (pop[p]),
        .full       (full[p]),
        .head_valid (head_valid[p]),
        .head       (head_data[p*MSG_W +: MSG_W])
      );
      assign ptr_flat[p*PW +: PW] = ptr_q[p];
    end
  endgenerate

  xpt_route_tbl #(.NPORT(NPORT), .ID_W(ID_W), .PW(PW)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (tbl_we),
    .waddr    (tbl_addr),
    .wport    (tbl_port),
    .tbl_flat (tbl_flat)
  );

  xpt_central #(.N(NPORT), .MSG_W(MSG_W), .ID_W(ID_W), .PW(PW)) u_core (
    .head_valid (head_valid),
    .head_data  (head_data),
    .tbl_flat   (tbl_flat),
    .ptr_flat   (ptr_flat),
    .pop        (pop),
    .loop_hit   (loop_hit),
    .sel_valid  (sel_valid),
    .sel_data   (sel_data),
    .win_flat   (win_flat),
    .gnt_flat   (gnt_flat)
  );

  // output registers, round-robin pointers, sticky loop flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= '0;
      loop_err_q  <= 1'b0;
      for (int o = 0; o < NPORT; o++) ptr_q[o] <= '0;
    end else begin
      out_valid_q <= sel_valid;
      loop_err_q  <= loop_err_q | (|loop_hit);
      for (int o = 0; o < NPORT; o++)
        if (sel_valid[o])
          ptr_q[o] <= PW'(xpt_pkg::xpt_next(int'(win_flat[o*PW +: PW]), NPORT));
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NPORT; o++)
      if (sel_valid[o]) out_data_q[o*MSG_W +: MSG_W] <= sel_data[o*MSG_W +: MSG_W];
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign loop_err  = loop_err_q;

  // R8
  loop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_err |=> loop_err);

  generate
    for (genvar q = 0; q < NPORT; q++) begin : g_chk
      logic [NPORT-1:0] col;
      always_comb for (int o = 0; o < NPORT; o++) col[o] = gnt_flat[o*NPORT + q];
      // R6
      grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col));
      // R4
      no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_flat[q*NPORT + q]);
    end
  endgenerate
endmodule

// File: tb/msg_xpoint_tb.sv
module msg_xpoint_tb_top;
  localparam int NP = 7;
  localparam int MW = 45;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP*MW-1:0]  in_data = '0;
  logic [NP-1:0]     in_ready;
  logic [NP-1:0]     out_valid;
  logic [NP*MW-1:0]  out_data;
  logic              tbl_we = 1'b0;
  logic [4:0]        tbl_addr = '0;
  logic [2:0]        tbl_port = '0;
  logic              loop_err;

  always #5 clk = ~clk;

  msg_xpoint dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_port(tbl_port), .loop_err(loop_err));

  int checks = 0, fails = 0;
  logic [MW-1:0] snd_q [NP][$];
  logic [MW-1:0] mq [NP][$];
  int tbl [32];
  int rr [NP];
  bit exp_v [NP];
  logic [MW-1:0] exp_d [NP];
  bit exp_err;
  int seq_ctr = 0, cyc = 0;
  int rec_cnt [NP];
  int first_cyc [NP];
  int rec_src [NP][$];
  int last_seq [NP][NP];
  bit seen_low [NP];
  int dut_deliv = 0, mdl_deliv = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int p, input int id);
    logic [MW-1:0] m;
    m = {5'(id), 3'(p), 37'(seq_ctr)};
    seq_ctr++;
    snd_q[p].push_back(m);
  endtask

  task automatic clear_rec();
    cyc = 0;
    for (int o = 0; o < NP; o++) begin
      rec_cnt[o] = 0; first_cyc[o] = -1; rec_src[o].delete(); seen_low[o] = 0;
    end
  endtask

  // one clock: drive at negedge, predict, compare after the next edge
  task automatic step();
    bit hv [NP];
    int dst [NP];
    bit pp [NP];
    bit rdy [NP];
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = snd_q[i].size() > 0;
      in_data[i*MW +: MW] = in_valid[i] ? snd_q[i][0] : '0;
    end
    #1;
    for (int i = 0; i < NP; i++) begin
      rdy[i] = mq[i].size() < 4;
      if (!in_ready[i]) seen_low[i] = 1;
      // R2
      chk(in_ready[i] == rdy[i], "R2", "in_ready", in_ready[i], rdy[i]);
    end
    for (int i = 0; i < NP; i++) begin
      hv[i] = mq[i].size() > 0;
      dst[i] = hv[i] ? tbl[mq[i][0][44:40]] : -1;
      pp[i] = hv[i] && dst[i] == i;
      if (pp[i]) exp_err = 1;
    end
    for (int o = 0; o < NP; o++) begin
      int nrr;
      exp_v[o] = 0;
      nrr = rr[o];
      for (int k = 0; k < NP; k++) begin
        int i;
        i = (rr[o] + k) % NP;
        if (!exp_v[o] && i != o && hv[i] && dst[i] == o) begin
          exp_v[o] = 1; exp_d[o] = mq[i][0]; pp[i] = 1; nrr = (i + 1) % NP;
        end
      end
      rr[o] = nrr;
      if (exp_v[o]) mdl_deliv++;
    end
    for (int i = 0; i < NP; i++) begin
      if (pp[i]) void'(mq[i].pop_front());
      if (in_valid[i] && rdy[i]) mq[i].push_back(snd_q[i].pop_front());
    end
    if (tbl_we && tbl_port < 7) tbl[tbl_addr] = tbl_port;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    for (int o = 0; o < NP; o++) begin
      // R5 R10: per-output valid and word against the model
      chk(out_valid[o] == exp_v[o], "R10", "out_valid", out_valid[o], exp_v[o]);
      if (exp_v[o] && out_valid[o])
        chk(out_data[o*MW +: MW] == exp_d[o], "R5", "out_data", out_data[o*MW +: MW], exp_d[o]);
      if (out_valid[o]) begin
        int s, q;
        s = int'(out_data[o*MW + 37 +: 3]);
        q = int'(out_data[o*MW +: 37]);
        dut_deliv++;
        rec_cnt[o]++;
        if (first_cyc[o] < 0) first_cyc[o] = cyc;
        rec_src[o].push_back(s);
        // R3 order per input/output pair
        chk(q > last_seq[s][o], "R3", "order", q, last_seq[s][o] + 1);
        last_seq[s][o] = q;
      end
    end
    chk(loop_err == exp_err, "R8", "loop_err", loop_err, exp_err);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic wr(input int a, input int p);
    tbl_we = 1; tbl_addr = 5'(a); tbl_port = 3'(p);
    step();
    tbl_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) tbl[i] = i % NP;
    for (int o = 0; o < NP; o++) begin
      rr[o] = 0;
      for (int s = 0; s < NP; s++) last_seq[s][o] = -1;
    end
    exp_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(in_ready == 7'h7f, "R1", "in_ready", in_ready, 7'h7f);
    chk(out_valid == 7'h0, "R1", "out_valid", out_valid, 0);
    chk(loop_err == 1'b0, "R1", "loop_err", loop_err, 0);
    @(negedge clk);

    // R1 default table: id 9 -> port 2
    clear_rec();
    send(0, 9);
    idle(3);
    chk(rec_cnt[2] == 1, "R1", "default entry delivery", rec_cnt[2], 1);

    // R9 write id10->4, write of 7 to id31 ignored (stays 3); R4 identifier decode
    wr(10, 4);
    wr(31, 7);
    clear_rec();
    send(0, 10);
    send(1, 31);
    idle(4);
    chk(rec_cnt[4] == 1 && rec_src[4][0] == 0, "R4", "id10 on port 4", rec_cnt[4], 1);
    chk(rec_cnt[3] == 1 && rec_src[3][0] == 1, "R9", "ignored write keeps port 3", rec_cnt[3], 1);

    // R5 latency and one word per clock
    clear_rec();
    for (int k = 0; k < 8; k++) send(1, 2);
    idle(12);
    chk(first_cyc[2] == 2, "R5", "first arrival cycle", first_cyc[2], 2);
    chk(rec_cnt[2] == 8, "R5", "stream count", rec_cnt[2], 8);
    chk(in_ready == 7'h7f, "R10", "ready after drain", in_ready, 7'h7f);

    // R6 round-robin among ports 1,3,5 toward port 0
    clear_rec();
    for (int k = 0; k < 2; k++) begin send(1, 0); send(3, 0); send(5, 0); end
    idle(10);
    chk(rec_cnt[0] == 6, "R6", "contended count", rec_cnt[0], 6);
    if (rec_cnt[0] == 6) begin
      int expv [6] = '{1, 3, 5, 1, 3, 5};
      for (int k = 0; k < 6; k++)
        chk(rec_src[0][k] == expv[k], "R6", "grant order", rec_src[0][k], expv[k]);
    end

    // R2 R7 back-pressure: ports 2 and 4 both stream into port 6
    clear_rec();
    for (int k = 0; k < 8; k++) begin send(4, 6); send(2, 6); end
    idle(24);
    chk(seen_low[4] == 1, "R2", "in_ready dropped when full", seen_low[4], 1);
    chk(rec_cnt[6] == 16, "R7", "losers delivered later", rec_cnt[6], 16);

    // R8 self-routed word dropped, flag sticky
    clear_rec();
    send(5, 5);
    idle(3);
    chk(loop_err == 1'b1, "R8", "loop_err set", loop_err, 1);
    chk(rec_cnt[5] == 0 && rec_cnt[0] == 0, "R8", "nothing forwarded", rec_cnt[5], 0);
    idle(5);
    chk(loop_err == 1'b1, "R8", "loop_err sticky", loop_err, 1);
    chk(out_valid == 7'h0, "R10", "idle outputs", out_valid, 0);

    // mixed traffic
    for (int c = 0; c < 1500; c++) begin
      for (int p = 0; p < NP; p++)
        if (snd_q[p].size() < 2 && ($urandom % 3 == 0)) send(p, int'($urandom % 32));
      step();
    end
    idle(80);
    chk(dut_deliv == mdl_deliv, "R3", "total delivered", dut_deliv, mdl_deliv);
    for (int p = 0; p < NP; p++)
      chk(mq[p].size() == 0 && snd_q[p].size() == 0, "R3", "drained", mq[p].size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule